// File: doc/BRIEF.md
# Differential ADC Frame Reader

This block is the host side of a link to a 13-bit differential successive-approximation converter that uses a mode-0 serial port. A request names one of eight input channels and a flag that selects single-ended or differential pairing. The block then lowers chip select and runs one 24-clock frame made of three back-to-back byte transfers. A small byte engine shifts each byte and is fed by a frame sequencer.

The outgoing frame starts with four zeros, followed by the start bit, the pairing flag and the three channel bits. Every later bit is sent as zero. Because of these leading zeros, the null bit, the sign bit and the twelve magnitude bits fall in fixed places, and the 13 result bits are the last 13 bits of the frame. The block keeps those bits and drops everything received before them. It sign-extends the 13-bit two's-complement code to 16 bits and reports it with a one-cycle done strobe.

The serial clock is made from the system clock. Each half period lasts a parameterised number of system cycles.

Top module: `adc_frame_reader`

## Requirements
- R1: Every accepted request produces exactly 24 rising serial-clock edges, sent as three 8-bit transfers, and chip select stays low from the first edge to the last.
- R2: The 24 bits presented on mosi at the rising edges are, in order: 0,0,0,0, then 1 (start), then the single-ended flag (1 = single-ended), then channel bits 2,1,0, then fifteen zeros.
- R3: The serial clock is low whenever chip select is high. Mosi changes only while the serial clock is low. Miso is sampled on rising serial-clock edges.
- R4: The result is the last 13 bits received, MSB first, read as two's complement (a 1 in bit 12 means the negative input was higher) and sign-extended to 16 bits. The 11 bits received before them have no effect on the result.
- R5: Chip select falls at least one half period before the first rising edge and rises at least one half period after the last falling edge.
- R6: done is high for exactly one system cycle per frame. result is valid in that cycle and holds until the next done.
- R7: A request that arrives while busy is high is ignored. It does not alter the running frame and does not start another one.
- R8: Each high phase of the serial clock lasts exactly HALF_DIV system cycles, and each low phase lasts at least HALF_DIV cycles.
- R9: After reset, chip select is high, the serial clock is low, and busy, done and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a conversion read (accepted only when not busy) |
| req_chan | input | 3 | Channel number for the request |
| req_single | input | 1 | 1 = single-ended, 0 = differential pair |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | 16 | Sign-extended two's-complement conversion code |
| spi_csn | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Data from the converter |

## Verification
The bench connects the reader to a behavioural converter. That model drives ones in the leading positions, the null slot included, so a reader that keeps the wrong 13 bits or mixes in junk returns a visibly wrong value. The two extreme codes, -4096 and +4095, together with -1 and 0, catch a decoder that extends from the wrong bit or drops the sign. The bench captures the command bits that the slave sees for all sixteen channel and mode pairs, which shows an off-by-one in zero padding or in channel bit order. The bench also measures the setup, hold and high-phase widths of every frame, and it fires a second request in the middle of a frame to catch a reader that restarts or changes its command.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int FRAME_BYTES = 3;
    localparam int FRAME_BITS  = FRAME_BYTES * 8;
    localparam int RES_BITS    = 13;
    localparam int OUT_BITS    = 16;
    localparam int LEAD_ZEROS  = 4;
    localparam int TAIL_ZEROS  = FRAME_BITS - LEAD_ZEROS - 5;

    typedef struct packed {
        logic       single;
        logic [2:0] chan;
    } adc_cmd_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_XFER,
        SEQ_HOLD
    } seq_state_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH
    } eng_state_t;

    function automatic logic [FRAME_BITS-1:0] build_tx(input adc_cmd_t cmd);
        return {{LEAD_ZEROS{1'b0}}, 1'b1, cmd.single, cmd.chan, {TAIL_ZEROS{1'b0}}};
    endfunction

    function automatic logic signed [OUT_BITS-1:0] decode_rx(input logic [FRAME_BITS-1:0] rx);
        return {{(OUT_BITS-RES_BITS){rx[RES_BITS-1]}}, rx[RES_BITS-1:0]};
    endfunction

endpackage

// File: rtl/adcrd_tick.sv
module adcrd_tick #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    a_r8_tick_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(HALF_DIV - 1));

endmodule

// File: rtl/adcrd_byte_engine.sv
module adcrd_byte_engine
    import adcrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       active,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    eng_state_t state;
    logic [7:0] sh;
    logic [2:0] bitn;

    assign active = (state != ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            sh        <= '0;
            bitn      <= '0;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        sh    <= tx_byte;
                        mosi  <= tx_byte[7];
                        bitn  <= '0;
                        state <= ENG_LOW;
                    end
                end
                ENG_LOW: begin
                    if (tick) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                        state   <= ENG_HIGH;
                    end
                end
                ENG_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            byte_done <= 1'b1;
                            state     <= ENG_IDLE;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            sh    <= {sh[6:0], 1'b0};
                            mosi  <= sh[6];
                            state <= ENG_LOW;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R3: data to the converter is held while the clock is high
    a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    a_r1_byte_ends_low: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> !sclk);

endmodule

// File: rtl/adcrd_sequencer.sv
module adcrd_sequencer
    import adcrd_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  adc_cmd_t                   req_cmd,
    input  logic                       tick,
    input  logic                       eng_done,
    input  logic [7:0]                 eng_rx,
    output logic                       eng_start,
    output logic [7:0]                 eng_tx,
    output logic                       tick_en,
    output logic                       csn,
    output logic                       busy,
    output logic                       done,
    output logic signed [OUT_BITS-1:0] result
);
    localparam int BW = $clog2(FRAME_BYTES);

    seq_state_t            state;
    adc_cmd_t              cmd_q;
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic [BW-1:0]         byte_idx;

    assign busy    = (state != SEQ_IDLE);
    assign tick_en = (state == SEQ_SETUP) || (state == SEQ_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            cmd_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            byte_idx  <= '0;
            eng_start <= 1'b0;
            eng_tx    <= '0;
            csn       <= 1'b1;
            done      <= 1'b0;
            result    <= '0;
        end else begin
            eng_start <= 1'b0;
            done      <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        cmd_q    <= req_cmd;
                        tx_q     <= build_tx(req_cmd);
                        byte_idx <= '0;
                        csn      <= 1'b0;
                        state    <= SEQ_SETUP;
                    end
                end
                SEQ_SETUP: begin
                    if (tick) begin
                        eng_start <= 1'b1;
                        eng_tx    <= tx_q[FRAME_BITS-1 -: 8];
                        tx_q      <= tx_q << 8;
                        state     <= SEQ_XFER;
                    end
                end
                SEQ_XFER: begin
                    if (eng_done) begin
                        rx_q <= {rx_q[FRAME_BITS-9:0], eng_rx};
                        if (byte_idx == BW'(FRAME_BYTES - 1)) begin
                            state <= SEQ_HOLD;
                        end else begin
                            byte_idx  <= byte_idx + 1'b1;
                            eng_start <= 1'b1;
                            eng_tx    <= tx_q[FRAME_BITS-1 -: 8];
                            tx_q      <= tx_q << 8;
                        end
                    end
                end
                SEQ_HOLD: begin
                    if (tick) begin
                        csn    <= 1'b1;
                        done   <= 1'b1;
                        result <= decode_rx(rx_q);
                        state  <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    a_r7_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(cmd_q)));

    a_r1_cs_low_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!csn || done));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int HALF_DIV = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_chan,
    input  logic        req_single,
    output logic        busy,
    output logic        done,
    output logic [15:0] result,
    output logic        spi_csn,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    adc_cmd_t   cmd;
    logic       tick, tick_en_seq, eng_active;
    logic       eng_start, eng_done;
    logic [7:0] eng_tx, eng_rx;
    logic signed [OUT_BITS-1:0] res_s;

    assign cmd.single = req_single;
    assign cmd.chan   = req_chan;
    assign result     = res_s;

    adcrd_tick #(.HALF_DIV(HALF_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .en   (tick_en_seq || eng_active),
        .tick (tick)
    );

    adcrd_byte_engine eng_i (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .tx_byte   (eng_tx),
        .tick      (tick),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .active    (eng_active),
        .byte_done (eng_done),
        .rx_byte   (eng_rx)
    );

    adcrd_sequencer seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_cmd   (cmd),
        .tick      (tick),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx),
        .eng_start (eng_start),
        .eng_tx    (eng_tx),
        .tick_en   (tick_en_seq),
        .csn       (spi_csn),
        .busy      (busy),
        .done      (done),
        .result    (res_s)
    );

    // Edge counter for the frame-length property (R1)
    logic       sclk_d;
    logic [5:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_d <= spi_sclk;
            if (!busy)                   rise_cnt <= '0;
            else if (spi_sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    a_r1_frame_len: assert property (@(posedge clk) disable iff (rst)
        done |-> (rise_cnt == 6'(FRAME_BITS)));

    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> !spi_sclk);

    a_r5_cs_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_csn) |=> !spi_sclk);

    a_r4_sign_ext: assert property (@(posedge clk) disable iff (rst)
        done |-> (result[15:13] == {3{result[12]}}));

endmodule

// File: tb/adc_frame_reader_tb_top.sv
`timescale 1ns/1ps
module adc_frame_reader_tb_top;
    localparam int HD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_chan = '0;
    logic req_single = 1'b0;
    logic busy, done, spi_csn, spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;
    logic [15:0] result;

    always #10 clk = ~clk;

    adc_frame_reader #(.HALF_DIV(HD)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .req_single(req_single), .busy(busy), .done(done), .result(result),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural converter
    logic [12:0] slv_code = '0;
    logic [23:0] slv_cmd = '0;
    int slv_rises = 0;

    function automatic logic slv_bit(input int m, input logic [12:0] c);
        if (m >= 12 && m <= 24) return c[24-m];
        if (m > 24) return 1'b0;
        return 1'b1;
    endfunction

    always @(negedge spi_csn) begin
        slv_rises = 0;
        slv_cmd   = '0;
        spi_miso  = slv_bit(1, slv_code);
    end
    always @(posedge spi_sclk) begin
        if (!spi_csn) begin
            slv_rises = slv_rises + 1;
            slv_cmd   = {slv_cmd[22:0], spi_mosi};
        end
    end
    always @(negedge spi_sclk) begin
        if (!spi_csn) spi_miso = slv_bit(slv_rises + 1, slv_code);
    end

    // Timing monitor, sampled away from the active edge
    int setup_cnt = 0, since_fall = 0, hi_cnt = 0, bad_hi = 0, cyc = 0;
    bit seen_rise = 0;
    always @(negedge clk) begin
        cyc++;
        if (spi_csn) begin
            seen_rise = 0;
            setup_cnt = 0;
        end else begin
            if (spi_sclk) seen_rise = 1;
            else if (!seen_rise) setup_cnt++;
            if (spi_sclk) since_fall = 0;
            else since_fall++;
        end
        if (spi_sclk) hi_cnt++;
        else if (hi_cnt != 0) begin
            if (hi_cnt != HD) bad_hi++;
            hi_cnt = 0;
        end
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_frame(input logic [2:0] ch, input logic sg, input int code, input bit mid_req);
        logic [23:0] exp_cmd;
        int exp_res, wait_n;
        slv_code = code[12:0];
        @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_single = sg;
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_req) begin
            repeat (20) @(negedge clk);
            req_valid = 1'b1; req_chan = ~ch; req_single = ~sg;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        check(done, "R6 done seen", done, 1);
        exp_res = (code < 0) ? code + 65536 : code;
        check(result == 16'(exp_res), "R4 result", result, exp_res);
        exp_cmd = {4'b0000, 1'b1, sg, ch, 15'b0};
        check(slv_cmd == exp_cmd, "R2 command bits", slv_cmd, exp_cmd);
        check(slv_rises == 24, "R1 clock count", slv_rises, 24);
        check(setup_cnt >= HD, "R5 cs setup", setup_cnt, HD);
        check(since_fall >= HD, "R5 cs hold", since_fall, HD);
        check(bad_hi == 0, "R8 high width", bad_hi, 0);
        @(negedge clk);
        check(!done, "R6 done one cycle", done, 0);
        check(result == 16'(exp_res), "R6 result held", result, exp_res);
        if (mid_req) begin
            repeat (200) @(negedge clk);
            check(spi_csn && !busy, "R7 no second frame", {busy, spi_csn}, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(spi_csn == 1'b1, "R9 csn reset", spi_csn, 1);
        check(spi_sclk == 1'b0, "R9 sclk reset", spi_sclk, 0);
        check(!busy && !done, "R9 busy/done reset", {busy, done}, 0);
        check(result == 16'd0, "R9 result reset", result, 0);
        // R3: clock idles low while deselected
        repeat (10) @(negedge clk);
        check(!spi_sclk && spi_csn, "R3 idle clock", spi_sclk, 0);

        // Extreme and near-zero codes (R4)
        run_frame(3'd0, 1'b0, -4096, 0);
        run_frame(3'd7, 1'b1, 4095, 0);
        run_frame(3'd2, 1'b0, -1, 0);
        run_frame(3'd5, 1'b1, 0, 0);
        run_frame(3'd1, 1'b0, 1, 0);
        // All channel and mode pairs (R2)
        for (int i = 0; i < 16; i++)
            run_frame(3'(i), 1'(i >> 3), i * 512 - 4096 + i * 3, 0);
        // Code sweep (R4)
        for (int k = 0; k < 64; k++)
            run_frame(3'(k), 1'(k), k * 128 + (k % 7) - 4096, 0);
        // Request during busy (R7)
        run_frame(3'd6, 1'b0, 1234, 1);
        run_frame(3'd3, 1'b1, -2222, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule